// File: doc/BRIEF.md
# Comparator Timer Channel

One channel of an event-timer block. The channel watches a free-running 64-bit main count supplied by its parent and raises a one-cycle fire strobe when the count reaches the channel's target. A target is armed from the visible comparator when the block is enabled, and again after every register write while it is enabled. In one-shot mode the channel fires once per arming. In periodic mode it adds a hidden period to the target after each fire and shows the new target in the comparator. A 32-bit compatibility mode matches only the low word of the count. In one-shot 32-bit mode the channel also fires once when the count crosses the next 32-bit boundary.

The parent register file writes the channel one half-word at a time. It gives a half select and the data. The channel returns its configuration word and its comparator for read-back. It also returns the fire strobe, a level-type status bit and an interrupt line gated by the channel's interrupt enable. Pin routing and message delivery are decided outside the channel. Their configuration fields are only stored here.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset, cfg_o reads {ROUTE_CAP, 16'h0000, 16'h0030 | MSG_CAP<<15}, cmp_o is all ones, and fire_o, sts_o and irq_o are 0.
- R2: A configuration write with hi_sel_i=0 stores wdata_i[15:0] & 16'h7F4E. Bit 1 selects level (1) or edge (0) status, bit 2 enables the interrupt, bit 3 selects periodic mode, bit 6 is value-set, bit 8 selects 32-bit mode, bits 13:9 hold a route index and bit 14 enables message delivery. Configuration writes with hi_sel_i=1 change nothing.
- R3: A comparator write loads the comparator half chosen by hi_sel_i when the channel is one-shot (bit 3 = 0) or value-set is 1. In periodic mode the same write also loads the period. Every accepted comparator write clears value-set.
- R4: In 32-bit mode, comparator writes with hi_sel_i=1 are ignored, and low-half data is zero-extended into both the comparator and the period. A configuration write that leaves bit 8 set cuts the comparator and the period to their low 32 bits.
- R5: In 64-bit one-shot mode, fire_o pulses for one cycle when the signed difference count_i - comparator is first non-negative. It does not pulse again until the channel is re-armed, and this holds across the 64-bit wrap.
- R6: In 32-bit mode the target is {count[63:32], comparator[31:0]} taken at arming, plus 2^32 if that value is below the count.
- R7: In one-shot 32-bit mode, if the target lies beyond the next 32-bit boundary of the count, the channel fires at that boundary and then fires again at the target.
- R8: On a periodic fire with a nonzero period, the target is raised by the period, and raised again while it is still below the count. cmp_o then shows the new target, cut to 32 bits in 32-bit mode.
- R9: With bit 1 = 1, a fire sets sts_o, and sts_o stays set until sts_clr_i. irq_o equals sts_o for level type and fire_o for edge type, and is 0 whenever bit 2 = 0.
- R10: A configuration write that clears bit 1 clears sts_o at the same edge.
- R11: No fire occurs while run_i is 0. A rising run_i re-arms the channel from the current comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | CNT_W | Running main count |
| run_i | input | 1 | Global enable of counting and firing |
| cfg_we_i | input | 1 | Configuration half-word write strobe |
| cmp_we_i | input | 1 | Comparator half-word write strobe |
| hi_sel_i | input | 1 | Write targets the upper half |
| wdata_i | input | CNT_W/2 | Write data |
| sts_clr_i | input | 1 | Clear the level status |
| cfg_o | output | 64 | Configuration and capability word |
| cmp_o | output | CNT_W | Visible comparator |
| fire_o | output | 1 | One-cycle fire strobe |
| sts_o | output | 1 | Level-type status |
| irq_o | output | 1 | Enabled interrupt line |

## Verification
One-shot 64-bit firing is swept over comparators from small values to values just below the 64-bit wrap. Stepping the count to one below the target, then to the target, then past it tells an off-by-one apart from repeated firing and from a sign error in the compare. The 32-bit sweep varies the count's upper word to show that only the low word is matched. A count just above the comparator's low word brings out the 2^32 correction and the extra fire at the boundary. Periodic runs jump the count over several periods, so a single add is told apart from a full catch-up. A comparator write with value-set clear shows that only the period moved.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int CFG_W  = 64;
  localparam int B_LVL  = 1;
  localparam int B_IEN  = 2;
  localparam int B_PER  = 3;
  localparam int B_VSET = 6;
  localparam int B_M32  = 8;
  localparam int B_MCAP = 15;
  localparam logic [15:0] CFG_WMASK = 16'h7F4E;
  localparam logic [15:0] CAP_FIXED = 16'h0030;
endpackage

// File: rtl/tchan_arm_calc.sv
module tchan_arm_calc #(
  parameter int CNT_W = 64
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             m32_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] target_o,
  output logic [CNT_W-1:0] deadline_o,
  output logic             wrap_o
);
  localparam int HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] STEP32 = {{(HALF-1){1'b0}}, 1'b1, {HALF{1'b0}}};
  localparam logic [HALF-1:0]  ONE_H  = {{(HALF-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] ext, nwrap;

  always_comb begin
    ext = {count_i[CNT_W-1:HALF], cmp_i[HALF-1:0]};
    if (ext < count_i) ext = ext + STEP32;
    nwrap      = {count_i[CNT_W-1:HALF] + ONE_H, {HALF{1'b0}}};
    target_o   = m32_i ? ext : cmp_i;
    wrap_o     = m32_i && !periodic_i && (ext > nwrap);
    deadline_o = wrap_o ? nwrap : target_o;
  end
endmodule

// File: rtl/tchan_regs.sv
module tchan_regs
  import cmp_timer_pkg::*;
#(
  parameter int          CNT_W     = 64,
  parameter bit          MSG_CAP   = 1'b1,
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0004
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic                  cmp_we_i,
  input  logic                  hi_sel_i,
  input  logic [CNT_W/2-1:0]    wdata_i,
  input  logic                  upd_i,
  input  logic [CNT_W-1:0]      upd_val_i,
  output logic [CFG_W-1:0]      cfg_o,
  output logic [CNT_W-1:0]      cmp_o,
  output logic [CNT_W-1:0]      period_o,
  output logic                  lvl_drop_o,
  output logic                  arm_req_o
);
  localparam int HALF = CNT_W / 2;
  localparam logic [15:0] RO_LO = CAP_FIXED | (16'(MSG_CAP) << B_MCAP);

  logic [15:0]      wbits_q, wbits_d;
  logic [CNT_W-1:0] cmp_q, cmp_d, per_q, per_d, cmp_w, per_w;
  logic             m32_n;

  assign cfg_o    = {ROUTE_CAP, 16'h0000, (wbits_q & CFG_WMASK) | RO_LO};
  assign cmp_o    = cmp_q;
  assign period_o = per_q;

  always_comb begin
    wbits_d    = wbits_q;
    cmp_d      = cmp_q;
    per_d      = per_q;
    cmp_w      = cmp_q;
    per_w      = per_q;
    lvl_drop_o = 1'b0;
    arm_req_o  = 1'b0;

    if (cfg_we_i) begin
      arm_req_o = 1'b1;
      if (!hi_sel_i) begin
        wbits_d    = wdata_i[15:0] & CFG_WMASK;
        lvl_drop_o = wbits_q[B_LVL] & ~wbits_d[B_LVL];
      end
    end
    m32_n = wbits_d[B_M32];
    if (cfg_we_i && !hi_sel_i && m32_n) begin
      cmp_d = {{HALF{1'b0}}, cmp_q[HALF-1:0]};
      per_d = {{HALF{1'b0}}, per_q[HALF-1:0]};
    end

    if (cmp_we_i && !(m32_n && hi_sel_i)) begin
      arm_req_o = 1'b1;
      if (m32_n) begin
        cmp_w = {{HALF{1'b0}}, wdata_i};
        per_w = {{HALF{1'b0}}, wdata_i};
      end else if (hi_sel_i) begin
        cmp_w = {wdata_i, cmp_d[HALF-1:0]};
        per_w = {wdata_i, per_d[HALF-1:0]};
      end else begin
        cmp_w = {cmp_d[CNT_W-1:HALF], wdata_i};
        per_w = {per_d[CNT_W-1:HALF], wdata_i};
      end
      if (!wbits_d[B_PER] || wbits_d[B_VSET]) cmp_d = cmp_w;
      if (wbits_d[B_PER]) per_d = per_w;
      wbits_d[B_VSET] = 1'b0;
    end else if (upd_i) begin
      cmp_d = m32_n ? {{HALF{1'b0}}, upd_val_i[HALF-1:0]} : upd_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbits_q <= '0;
      cmp_q   <= '1;
      per_q   <= '0;
    end else begin
      wbits_q <= wbits_d;
      cmp_q   <= cmp_d;
      per_q   <= per_d;
    end
  end
endmodule

// File: rtl/tchan_fire.sv
module tchan_fire #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             run_i,
  input  logic             arm_req_i,
  input  logic             periodic_i,
  input  logic             lvl_i,
  input  logic             lvl_drop_i,
  input  logic             sts_clr_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] a_target_i,
  input  logic [CNT_W-1:0] a_deadline_i,
  input  logic             a_wrap_i,
  output logic             fire_o,
  output logic             sts_o,
  output logic             upd_o,
  output logic [CNT_W-1:0] upd_val_o
);
  logic             run_q, pend_q, pend_d;
  logic             armed_q, armed_d, catch_q, catch_d, wrap_q, wrap_d;
  logic             fire_q, fire_d, sts_q, sts_d;
  logic [CNT_W-1:0] tgt_q, tgt_d, dl_q, dl_d;
  logic [CNT_W-1:0] diff_dl, diff_t, next_t;
  logic             reached, behind;

  // signed differences keep the compare valid across count wrap
  assign diff_dl   = count_i - dl_q;
  assign diff_t    = tgt_q - count_i;
  assign reached   = ~diff_dl[CNT_W-1];
  assign behind    = diff_t[CNT_W-1];
  assign next_t    = tgt_q + period_i;
  assign upd_val_o = next_t;
  assign fire_o    = fire_q;
  assign sts_o     = sts_q;

  always_comb begin
    armed_d = armed_q;
    catch_d = catch_q;
    wrap_d  = wrap_q;
    tgt_d   = tgt_q;
    dl_d    = dl_q;
    fire_d  = 1'b0;
    upd_o   = 1'b0;
    pend_d  = run_i & arm_req_i;

    if (!run_i) begin
      armed_d = 1'b0;
      catch_d = 1'b0;
    end else if (pend_q || !run_q) begin
      armed_d = 1'b1;
      catch_d = 1'b0;
      tgt_d   = a_target_i;
      dl_d    = a_deadline_i;
      wrap_d  = a_wrap_i;
    end else if (catch_q) begin
      if (behind) begin
        tgt_d = next_t;
        dl_d  = next_t;
        upd_o = 1'b1;
      end else begin
        catch_d = 1'b0;
      end
    end else if (armed_q && reached) begin
      fire_d = 1'b1;
      if (periodic_i && |period_i) begin
        tgt_d   = next_t;
        dl_d    = next_t;
        catch_d = 1'b1;
        upd_o   = 1'b1;
      end else if (wrap_q) begin
        wrap_d = 1'b0;
        dl_d   = tgt_q;
      end else begin
        armed_d = 1'b0;
      end
    end

    sts_d = sts_q;
    if (lvl_drop_i)           sts_d = 1'b0;
    else if (fire_d && lvl_i) sts_d = 1'b1;
    else if (sts_clr_i)       sts_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      catch_q <= 1'b0;
      wrap_q  <= 1'b0;
      fire_q  <= 1'b0;
      sts_q   <= 1'b0;
      tgt_q   <= '0;
      dl_q    <= '0;
    end else begin
      run_q   <= run_i;
      pend_q  <= pend_d;
      armed_q <= armed_d;
      catch_q <= catch_d;
      wrap_q  <= wrap_d;
      fire_q  <= fire_d;
      sts_q   <= sts_d;
      tgt_q   <= tgt_d;
      dl_q    <= dl_d;
    end
  end
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import cmp_timer_pkg::*;
#(
  parameter int          CNT_W     = 64,
  parameter bit          MSG_CAP   = 1'b1,
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0004
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   count_i,
  input  logic               run_i,
  input  logic               cfg_we_i,
  input  logic               cmp_we_i,
  input  logic               hi_sel_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  input  logic               sts_clr_i,
  output logic [CFG_W-1:0]   cfg_o,
  output logic [CNT_W-1:0]   cmp_o,
  output logic               fire_o,
  output logic               sts_o,
  output logic               irq_o
);
  logic [CNT_W-1:0] period, a_target, a_deadline, upd_val;
  logic             a_wrap, upd, lvl_drop, arm_req;

  tchan_regs #(.CNT_W(CNT_W), .MSG_CAP(MSG_CAP), .ROUTE_CAP(ROUTE_CAP)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cmp_we_i, .hi_sel_i, .wdata_i,
    .upd_i(upd), .upd_val_i(upd_val),
    .cfg_o, .cmp_o, .period_o(period),
    .lvl_drop_o(lvl_drop), .arm_req_o(arm_req)
  );

  tchan_arm_calc #(.CNT_W(CNT_W)) u_arm (
    .count_i, .cmp_i(cmp_o), .m32_i(cfg_o[B_M32]), .periodic_i(cfg_o[B_PER]),
    .target_o(a_target), .deadline_o(a_deadline), .wrap_o(a_wrap)
  );

  tchan_fire #(.CNT_W(CNT_W)) u_fire (
    .clk_i, .rst_ni, .count_i, .run_i,
    .arm_req_i(arm_req), .periodic_i(cfg_o[B_PER]), .lvl_i(cfg_o[B_LVL]),
    .lvl_drop_i(lvl_drop), .sts_clr_i, .period_i(period),
    .a_target_i(a_target), .a_deadline_i(a_deadline), .a_wrap_i(a_wrap),
    .fire_o, .sts_o, .upd_o(upd), .upd_val_o(upd_val)
  );

  assign irq_o = cfg_o[B_IEN] & (cfg_o[B_LVL] ? sts_o : fire_o);
endmodule

// File: rtl/cmp_timer_chan_chk.sv
module cmp_timer_chan_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             cfg_we_i,
  input logic             cmp_we_i,
  input logic             hi_sel_i,
  input logic [63:0]      cfg_o,
  input logic [CNT_W-1:0] cmp_o,
  input logic             fire_o,
  input logic             sts_o
);
  localparam int HALF = CNT_W / 2;

  // R11
  fire_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(run_i));

  // R9
  sts_rise_with_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o) |-> fire_o);

  // R2
  cfg_hi_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && hi_sel_i && !cmp_we_i) |=> $stable(cfg_o));

  // R4
  m32_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[8] |-> (cmp_o[CNT_W-1:HALF] == '0));

  // R10
  lvl_drop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_o[1]) |-> !sts_o);

  // R3
  vset_self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_we_i && !cfg_we_i && !(cfg_o[8] && hi_sel_i)) |=> !cfg_o[6]);
endmodule

bind cmp_timer_chan cmp_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .cfg_we_i(cfg_we_i),
  .cmp_we_i(cmp_we_i), .hi_sel_i(hi_sel_i), .cfg_o(cfg_o), .cmp_o(cmp_o),
  .fire_o(fire_o), .sts_o(sts_o)
);

// File: tb/tb_cmp_timer_chan.sv
module tb_cmp_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        run = 1'b0, cfg_we = 1'b0, cmp_we = 1'b0, hi = 1'b0, clr = 1'b0;
  logic [31:0] wd = '0;
  logic [63:0] cfg, cmpv;
  logic        fire, sts, irq;
  int checks = 0, errors = 0, fires = 0, irqs = 0;

  always #5 clk = ~clk;

  cmp_timer_chan dut (
    .clk_i(clk), .rst_ni(rst_n), .count_i(cnt), .run_i(run),
    .cfg_we_i(cfg_we), .cmp_we_i(cmp_we), .hi_sel_i(hi), .wdata_i(wd),
    .sts_clr_i(clr), .cfg_o(cfg), .cmp_o(cmpv), .fire_o(fire), .sts_o(sts), .irq_o(irq)
  );

  always @(negedge clk) if (rst_n) begin
    fires += int'(fire);
    irqs  += int'(irq);
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run = 1'b0; cfg_we = 1'b0; cmp_we = 1'b0; hi = 1'b0; clr = 1'b0; cnt = '0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic wr(input bit is_cmp, input bit hsel, input logic [31:0] d);
    cfg_we = !is_cmp; cmp_we = is_cmp; hi = hsel; wd = d;
    step(1);
    cfg_we = 1'b0; cmp_we = 1'b0;
    step(1);
  endtask

  task automatic go(input logic [63:0] c, input int n);
    cnt = c;
    step(n);
  endtask

  localparam logic [63:0] RST_CFG = {32'h00F0_0004, 32'h0000_8030};

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    logic [63:0] cv [4];
    logic [31:0] up [3];
    cv[0] = 64'h10; cv[1] = 64'h1_0000_0000; cv[2] = 64'h1234_5678_9ABC_DEF0; cv[3] = 64'hFFFF_FFFF_FFFF_FFFE;
    up[0] = 32'h0; up[1] = 32'h5; up[2] = 32'h7FFF_FFFF;

    // R1 reset state
    do_reset();
    chk("R1 cfg", cfg, RST_CFG);
    chk("R1 cmp", cmpv, '1);
    chk("R1 outs", {61'd0, fire, sts, irq}, 64'd0);

    // R2 mask and upper-half ignore; R4 truncation on 32-bit entry
    wr(1'b0, 1'b0, 32'hFFFF_FFFF);
    chk("R2 mask", cfg, {32'h00F0_0004, 32'h0000_FF7E});
    chk("R4 trunc on m32", cmpv, 64'h0000_0000_FFFF_FFFF);
    wr(1'b0, 1'b1, 32'h0000_0000);
    chk("R2 hi ignored", cfg, {32'h00F0_0004, 32'h0000_FF7E});
    wr(1'b0, 1'b0, 32'h0);
    chk("R2 clear", cfg, RST_CFG);

    // R5 one-shot 64-bit sweep
    for (int i = 0; i < 4; i++) begin
      do_reset();
      wr(1'b1, 1'b1, cv[i][63:32]);
      wr(1'b1, 1'b0, cv[i][31:0]);
      chk("R5 cmp load", cmpv, cv[i]);
      cnt = cv[i] - 64'd5; run = 1'b1; step(2);
      base = fires;
      go(cv[i] - 64'd1, 3);
      chk("R5 early", 64'(fires - base), 64'd0);
      go(cv[i], 3);
      chk("R5 match", 64'(fires - base), 64'd1);
      go(cv[i] + 64'd3, 3);
      chk("R5 once", 64'(fires - base), 64'd1);
    end

    // R6 32-bit target sweep over upper words
    for (int i = 0; i < 3; i++) begin
      do_reset();
      wr(1'b0, 1'b0, 32'h100);
      wr(1'b1, 1'b0, 32'h80);
      cnt = {up[i], 32'h10}; run = 1'b1; step(2);
      base = fires;
      go({up[i], 32'h7F}, 3);
      chk("R6 early", 64'(fires - base), 64'd0);
      go({up[i], 32'h80}, 3);
      chk("R6 match", 64'(fires - base), 64'd1);
    end

    // R7 extra fire at 32-bit boundary
    do_reset();
    wr(1'b0, 1'b0, 32'h100);
    wr(1'b1, 1'b0, 32'h80);
    cnt = 64'h5_0000_0090; run = 1'b1; step(2);
    base = fires;
    go(64'h5_FFFF_FFFF, 3);
    chk("R7 before wrap", 64'(fires - base), 64'd0);
    go(64'h6_0000_0000, 3);
    chk("R7 wrap fire", 64'(fires - base), 64'd1);
    go(64'h6_0000_007F, 3);
    chk("R7 between", 64'(fires - base), 64'd1);
    go(64'h6_0000_0080, 3);
    chk("R7 target fire", 64'(fires - base), 64'd2);
    go(64'h6_0000_0100, 3);
    chk("R7 done", 64'(fires - base), 64'd2);

    // R3 / R8 periodic 64-bit
    do_reset();
    wr(1'b0, 1'b0, 32'h8);
    wr(1'b1, 1'b0, 32'h100);
    chk("R3 periodic no vset keeps cmp", cmpv, '1);
    wr(1'b0, 1'b0, 32'h48);
    chk("R3 vset set", 64'(cfg[6]), 64'd1);
    wr(1'b1, 1'b0, 32'h200);
    chk("R3 vset load", cmpv, 64'hFFFF_FFFF_0000_0200);
    chk("R3 vset cleared", 64'(cfg[6]), 64'd0);
    wr(1'b0, 1'b0, 32'h48);
    wr(1'b1, 1'b1, 32'h0);
    chk("R3 hi load", cmpv, 64'h200);
    cnt = 64'h1F0; run = 1'b1; step(2);
    base = fires;
    go(64'h1FF, 3);
    chk("R8 early", 64'(fires - base), 64'd0);
    go(64'h200, 3);
    chk("R8 fire", 64'(fires - base), 64'd1);
    chk("R8 reload", cmpv, 64'h400);
    go(64'h3FF, 3);
    chk("R8 no refire", 64'(fires - base), 64'd1);
    go(64'h900, 6);
    chk("R8 catch fire", 64'(fires - base), 64'd2);
    chk("R8 catch cmp", cmpv, 64'hA00);
    wr(1'b1, 1'b0, 32'h50);
    chk("R3 period only", cmpv, 64'hA00);
    go(64'hA00, 4);
    chk("R3 new period fire", 64'(fires - base), 64'd3);
    chk("R3 new period cmp", cmpv, 64'hA50);

    // R4 / R8 periodic 32-bit
    do_reset();
    wr(1'b0, 1'b0, 32'h148);
    wr(1'b1, 1'b0, 32'hFFFF_FFF0);
    wr(1'b1, 1'b0, 32'h20);
    chk("R4 zext", cmpv, 64'h0000_0000_FFFF_FFF0);
    wr(1'b1, 1'b1, 32'hABCD);
    chk("R4 hi ignored", cmpv, 64'h0000_0000_FFFF_FFF0);
    cnt = 64'h3_FFFF_FF00; run = 1'b1; step(2);
    base = fires;
    go(64'h3_FFFF_FFF0, 4);
    chk("R8 m32 fire", 64'(fires - base), 64'd1);
    chk("R8 m32 cmp", cmpv, 64'h10);
    go(64'h4_0000_0010, 4);
    chk("R8 m32 refire", 64'(fires - base), 64'd2);
    chk("R8 m32 cmp2", cmpv, 64'h30);

    // R9 / R10 status and irq
    do_reset();
    wr(1'b0, 1'b0, 32'h6);
    wr(1'b1, 1'b1, 32'h0);
    wr(1'b1, 1'b0, 32'h40);
    run = 1'b1; step(2);
    go(64'h40, 3);
    chk("R9 level sts", {63'd0, sts}, 64'd1);
    chk("R9 level irq", {63'd0, irq}, 64'd1);
    clr = 1'b1; step(1); clr = 1'b0;
    chk("R9 clear", {62'd0, sts, irq}, 64'd0);
    wr(1'b1, 1'b0, 32'h80);
    go(64'h80, 3);
    chk("R9 sts again", {63'd0, sts}, 64'd1);
    wr(1'b0, 1'b0, 32'h4);
    chk("R10 level to edge", {63'd0, sts}, 64'd0);
    wr(1'b1, 1'b0, 32'hC0);
    base = irqs;
    go(64'hC0, 3);
    chk("R9 edge irq pulse", 64'(irqs - base), 64'd1);
    chk("R9 edge no sts", {63'd0, sts}, 64'd0);
    wr(1'b0, 1'b0, 32'h2);
    wr(1'b1, 1'b0, 32'h100);
    base = irqs;
    go(64'h100, 3);
    chk("R9 ien off sts", {63'd0, sts}, 64'd1);
    chk("R9 ien off irq", 64'(irqs - base), 64'd0);

    // R11 run gating
    do_reset();
    wr(1'b1, 1'b1, 32'h0);
    wr(1'b1, 1'b0, 32'h50);
    base = fires;
    go(64'h60, 3);
    chk("R11 stopped", 64'(fires - base), 64'd0);
    run = 1'b1; step(3);
    chk("R11 rearm on run", 64'(fires - base), 64'd1);
    run = 1'b0;
    wr(1'b1, 1'b0, 32'h70);
    go(64'h80, 3);
    chk("R11 stopped again", 64'(fires - base), 64'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule